// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block sits between a bus interface and an execution unit. It holds a fetch pointer and runs bus fetch cycles of a fixed number of clocks to read instruction bytes ahead of use. The bytes go into a small byte FIFO, and the consumer takes them one at a time through a valid/ready port. A new fetch starts only when the queue has enough free space for it. A redirect input empties the queue and reloads the pointer for a control transfer. A busy input from the execution unit holds off new fetches while that unit uses the bus for data.

A parameter selects the bus width. In the 16-bit mode the queue holds six bytes. A fetch from an even address brings in two bytes, and a fetch from an odd address brings in one byte, which puts later fetches back on even addresses. In the 8-bit mode the queue holds four bytes and every fetch brings in one byte.

Top module: `pfq_ctrl`

## Requirements
- R1: While reset is held, `out_valid` and `bus_req` are low. At the first clock edge after reset is released, a fetch starts at address `RST_ADDR` (0 by default).
- R2: With the consumer stalled, the queue holds exactly 6 bytes in the 16-bit mode and 4 bytes in the 8-bit mode, and no further fetch starts.
- R3: A fetch starts only if the free space, counting the bytes pushed and popped in the same cycle, is at least 2 bytes in the 16-bit mode or at least 1 byte in the 8-bit mode.
- R4: A fetch keeps `bus_req` high for exactly `FETCH_LAT` (4) consecutive clocks, with `bus_addr` and `bus_word` stable. `bus_rdata` is sampled in the last of those clocks.
- R5: Each fetch address equals the previous fetch address plus the number of bytes that fetch brought in. In the 16-bit mode, an even address has `bus_word`=1, and the byte in `bus_rdata[7:0]` comes out first, followed by the byte in `bus_rdata[15:8]`. An odd address has `bus_word`=0 and delivers only `bus_rdata[15:8]`. In the 8-bit mode `bus_word`=0 and the byte comes from `bus_rdata[7:0]`.
- R6: When the queue is empty, `out_valid` rises in the clock right after the last clock of the fetch. Bytes leave in ascending address order.
- R7: A redirect pulse empties the queue: `out_valid` is low in the next clock. The next fetch that starts uses the redirect address.
- R8: A fetch already running when a redirect arrives completes on the bus with its address unchanged. Its data is discarded, so the first byte delivered after the redirect is the byte at the target address.
- R9: While `eu_data_busy` is high, no new fetch starts, but a running fetch completes. Fetching resumes in the clock after `eu_data_busy` falls.
- R10: A push and a pop in the same clock both take effect. No byte is lost or repeated when the consumer and the bus are active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | One-clock pulse: empty the queue and fetch from `redir_addr` |
| redir_addr | input | ADDR_W | Redirect target address |
| eu_data_busy | input | 1 | The execution unit holds the bus for data; do not start new fetches |
| bus_req | output | 1 | High during each clock of a fetch cycle |
| bus_addr | output | ADDR_W | Byte address of the current fetch |
| bus_word | output | 1 | 1 when the current fetch returns two bytes |
| bus_rdata | input | 16 | Read data, valid in the last clock of a fetch cycle |
| out_valid | output | 1 | The queue holds at least one byte |
| out_ready | input | 1 | The consumer takes the head byte at this edge |
| out_data | output | 8 | Head byte of the queue |

## Verification
The assertions assume that `redir_valid` is a pulse driven between clock edges, and that `bus_rdata` reflects the fetched address by the last clock of each fetch. The bench drives every input at the falling edge. It builds `bus_rdata` combinationally from `bus_addr` using a fixed address-to-byte function, and never asserts `out_ready` during a redirect clock. The expected byte values come from that same function of the address, so each ordering, lane-selection and discard case can be checked against the address sequence alone.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

   // Queue size implied by the bus width option.
   function automatic int q_depth(input bit bus16);
      return bus16 ? 6 : 4;
   endfunction

   // Free bytes required before another fetch may begin.
   function automatic int free_min(input bit bus16);
      return bus16 ? 2 : 1;
   endfunction

endpackage

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
   parameter int DEPTH = 6,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [1:0]       push_n,
   input  logic [7:0]       push_b0,
   input  logic [7:0]       push_b1,
   input  logic             pop,
   output logic [CNT_W-1:0] count,
   output logic [7:0]       head
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [7:0]       mem [DEPTH];
   logic [IDX_W-1:0] wp_q, rp_q;
   logic [CNT_W-1:0] cnt_q;

   function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i,
                                              input logic [1:0] inc);
      logic [IDX_W:0] s;
      s = {1'b0, i} + (IDX_W+1)'(inc);
      if (s >= (IDX_W+1)'(DEPTH)) s = s - (IDX_W+1)'(DEPTH);
      return s[IDX_W-1:0];
   endfunction

   always_ff @(posedge clk) begin
      if (!flush) begin
         if (push_n != 2'd0) mem[wp_q] <= push_b0;
         if (push_n == 2'd2) mem[step(wp_q, 2'd1)] <= push_b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         wp_q  <= step(wp_q, push_n);
         rp_q  <= step(rp_q, {1'b0, pop});
         cnt_q <= cnt_q + CNT_W'(push_n) - CNT_W'(pop);
      end
   end

   assign count = cnt_q;
   assign head  = mem[rp_q];

endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch #(
   parameter bit BUS16     = 1'b1,
   parameter int ADDR_W    = 20,
   parameter int FETCH_LAT = 4,
   parameter logic [ADDR_W-1:0] RST_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redir,
   input  logic [ADDR_W-1:0] redir_addr,
   input  logic              hold,
   input  logic              space_ok,
   input  logic [15:0]       rdata,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_word,
   output logic [1:0]        push_n,
   output logic [7:0]        push_b0,
   output logic [7:0]        push_b1
);
   localparam int LW = $clog2(FETCH_LAT + 1);

   logic              busy_q, word_q, drop_q;
   logic [LW-1:0]     lat_q;
   logic [ADDR_W-1:0] ptr_q, addr_q;
   logic              done, start, word_new;
   logic [1:0]        n_new;

   // Byte count and lane mapping depend on the bus width option.
   generate
      if (BUS16) begin : g_bus16
         assign word_new = ~ptr_q[0];
         assign n_new    = ptr_q[0] ? 2'd1 : 2'd2;
         assign push_b0  = word_q ? rdata[7:0] : rdata[15:8];
         assign push_b1  = rdata[15:8];
      end else begin : g_bus8
         logic [7:0] unused_hi;
         assign unused_hi = rdata[15:8];
         assign word_new  = 1'b0;
         assign n_new     = 2'd1;
         assign push_b0   = rdata[7:0];
         assign push_b1   = 8'h00;
      end
   endgenerate

   assign done  = busy_q && (lat_q == LW'(FETCH_LAT - 1));
   assign start = (!busy_q || done) && !redir && !hold && space_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         lat_q  <= '0;
         word_q <= 1'b0;
         drop_q <= 1'b0;
         addr_q <= '0;
         ptr_q  <= RST_ADDR;
      end else begin
         if (start) begin
            busy_q <= 1'b1;
            lat_q  <= '0;
            addr_q <= ptr_q;
            word_q <= word_new;
            drop_q <= 1'b0;
            ptr_q  <= ptr_q + ADDR_W'(n_new);
         end else if (done) begin
            busy_q <= 1'b0;
            lat_q  <= '0;
            drop_q <= 1'b0;
         end else if (busy_q) begin
            lat_q <= lat_q + LW'(1);
            if (redir) drop_q <= 1'b1;
         end
         if (redir) ptr_q <= redir_addr;
      end
   end

   assign bus_req  = busy_q;
   assign bus_addr = addr_q;
   assign bus_word = word_q;
   assign push_n   = (done && !drop_q && !redir) ? (word_q ? 2'd2 : 2'd1) : 2'd0;

endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl #(
   parameter bit BUS16     = 1'b1,
   parameter int ADDR_W    = 20,
   parameter int FETCH_LAT = 4,
   parameter logic [ADDR_W-1:0] RST_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redir_valid,
   input  logic [ADDR_W-1:0] redir_addr,
   input  logic              eu_data_busy,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_word,
   input  logic [15:0]       bus_rdata,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data
);
   localparam int Q_DEPTH  = pfq_pkg::q_depth(BUS16);
   localparam int FREE_MIN = pfq_pkg::free_min(BUS16);
   localparam int CNT_W    = $clog2(Q_DEPTH + 1);

   generate
      if (FETCH_LAT < 1) begin : g_bad_lat
         $error("pfq_ctrl: FETCH_LAT must be at least 1");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("pfq_ctrl: ADDR_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] q_count;
   logic [CNT_W:0]   cnt_after;
   logic [1:0]       push_n;
   logic [7:0]       push_b0, push_b1;
   logic             pop, space_ok;

   assign out_valid = (q_count != '0);
   assign pop       = out_valid && out_ready && !redir_valid;
   assign cnt_after = {1'b0, q_count} + (CNT_W+1)'(push_n) - (CNT_W+1)'(pop);
   assign space_ok  = (Q_DEPTH - int'(cnt_after)) >= FREE_MIN;

   pfq_fetch #(
      .BUS16(BUS16), .ADDR_W(ADDR_W), .FETCH_LAT(FETCH_LAT), .RST_ADDR(RST_ADDR)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n),
      .redir(redir_valid), .redir_addr(redir_addr),
      .hold(eu_data_busy), .space_ok(space_ok), .rdata(bus_rdata),
      .bus_req(bus_req), .bus_addr(bus_addr), .bus_word(bus_word),
      .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1)
   );

   pfq_fifo #(.DEPTH(Q_DEPTH), .CNT_W(CNT_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(redir_valid),
      .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1),
      .pop(pop), .count(q_count), .head(out_data)
   );

endmodule

// File: rtl/pfq_ctrl_chk.sv
module pfq_ctrl_chk #(
   parameter bit BUS16     = 1'b1,
   parameter int ADDR_W    = 20,
   parameter int FETCH_LAT = 4,
   parameter int Q_DEPTH   = 6,
   parameter int CNT_W     = 3,
   parameter logic [ADDR_W-1:0] RST_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              redir_valid,
   input logic [ADDR_W-1:0] redir_addr,
   input logic              eu_data_busy,
   input logic              bus_req,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_word,
   input logic              out_valid,
   input logic [CNT_W-1:0]  q_count
);
   localparam int PW = $clog2(FETCH_LAT + 1);

   logic [PW-1:0]     ph_q;
   logic [ADDR_W-1:0] exp_q;
   logic              f_start;

   assign f_start = bus_req && (ph_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= '0;
         exp_q <= RST_ADDR;
      end else begin
         if (!bus_req) ph_q <= '0;
         else ph_q <= (ph_q == PW'(FETCH_LAT - 1)) ? '0 : ph_q + PW'(1);
         if (redir_valid) exp_q <= redir_addr;
         else if (f_start) exp_q <= bus_addr + ADDR_W'(bus_word ? 2 : 1);
      end
   end

   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      int'(q_count) <= Q_DEPTH);

   a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && ph_q != '0) |-> ($stable(bus_addr) && $stable(bus_word)));

   a_r4_cycle_len: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_req && ph_q != '0) |-> (ph_q == '0));

   a_r4_full_len: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && ph_q != PW'(FETCH_LAT - 1)) |=> bus_req);

   a_r5_width: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_word == (BUS16 && !bus_addr[0])));

   a_r5_sequential: assert property (@(posedge clk) disable iff (!rst_n)
      f_start |-> (bus_addr == exp_q));

   a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> !out_valid);

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (eu_data_busy && (!bus_req || ph_q == PW'(FETCH_LAT - 1))) |=> !bus_req);

endmodule

bind pfq_ctrl pfq_ctrl_chk #(
   .BUS16(BUS16), .ADDR_W(ADDR_W), .FETCH_LAT(FETCH_LAT),
   .Q_DEPTH(Q_DEPTH), .CNT_W(CNT_W), .RST_ADDR(RST_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_addr(redir_addr),
   .eu_data_busy(eu_data_busy), .bus_req(bus_req), .bus_addr(bus_addr),
   .bus_word(bus_word), .out_valid(out_valid), .q_count(q_count)
);

// File: tb/sim_pfq_ctrl.sv
`timescale 1ns/1ps
module sim_pfq_ctrl;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        redir_valid = 1'b0, eu_data_busy = 1'b0, out_ready = 1'b0;
   logic [19:0] redir_addr = '0;
   logic        bus_req, bus_word, out_valid;
   logic [19:0] bus_addr;
   logic [15:0] bus_rdata;
   logic [7:0]  out_data;

   logic        redir1 = 1'b0, eu1 = 1'b0, ready1 = 1'b0;
   logic [19:0] redir_addr1 = '0;
   logic        bus_req1, bus_word1, out_valid1;
   logic [19:0] bus_addr1;
   logic [15:0] bus_rdata1;
   logic [7:0]  out_data1;

   int checks = 0, failures = 0, cyc = 0;
   logic [7:0] log_b [256];
   int log_n = 0;

   function automatic logic [7:0] mb(input logic [19:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
   endfunction

   assign bus_rdata  = {mb(bus_addr | 20'h1), mb(bus_addr & ~20'h1)};
   assign bus_rdata1 = {8'h00, mb(bus_addr1)};

   pfq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_addr(redir_addr),
      .eu_data_busy(eu_data_busy), .bus_req(bus_req), .bus_addr(bus_addr),
      .bus_word(bus_word), .bus_rdata(bus_rdata), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data));

   pfq_ctrl #(.BUS16(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .redir_valid(redir1), .redir_addr(redir_addr1),
      .eu_data_busy(eu1), .bus_req(bus_req1), .bus_addr(bus_addr1),
      .bus_word(bus_word1), .bus_rdata(bus_rdata1), .out_valid(out_valid1),
      .out_ready(ready1), .out_data(out_data1));

   // Record every byte the consumer takes from u0.
   always @(negedge clk) begin
      #1;
      if (out_valid && out_ready && log_n < 256) begin
         log_b[log_n] = out_data;
         log_n++;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         finish_run();
      end
   end

   task automatic redirect(input logic [19:0] a);
      @(negedge clk);
      out_ready = 1'b0;
      redir_valid = 1'b1; redir_addr = a; log_n = 0;
      @(negedge clk);
      redir_valid = 1'b0;
   endtask

   task automatic wait_fetch(input logic [19:0] a, output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 200; i++) begin
         if (bus_req && bus_addr == a) begin ok = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic wait_log(input int n);
      for (int i = 0; i < 600 && log_n < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (4) @(negedge clk);
      chk("R1 out_valid in reset", out_valid, 0);
      chk("R1 bus_req in reset", bus_req, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 fetch after reset", bus_req, 1);
      chk("R1 first address", bus_addr, 20'h0);
   endtask

   task automatic t_stream();
      bit ok;
      redirect(20'h100);
      chk("R7 queue emptied", out_valid, 0);
      wait_fetch(20'h100, ok);
      chk("R7 fetch at target", ok, 1);
      repeat (3) @(negedge clk);
      chk("R6 no byte during fetch", out_valid, 0);
      @(negedge clk);
      chk("R6 byte right after fetch", out_valid, 1);
      chk("R6 head byte", out_data, mb(20'h100));
      out_ready = 1'b1;
      wait_log(16);
      @(negedge clk);
      out_ready = 1'b0;
      chk("R6 byte count", log_n >= 16, 1);
      for (int i = 0; i < 16; i++) chk("R6 order", log_b[i], mb(20'h100 + 20'(i)));
   endtask

   task automatic t_odd();
      bit ok;
      redirect(20'h201);
      wait_fetch(20'h201, ok);
      chk("R5 odd fetch seen", ok, 1);
      chk("R5 odd fetch single byte", bus_word, 0);
      wait_fetch(20'h202, ok);
      chk("R5 realigned fetch seen", ok, 1);
      chk("R5 even fetch is word", bus_word, 1);
      @(negedge clk); out_ready = 1'b1;
      wait_log(6);
      @(negedge clk); out_ready = 1'b0;
      for (int i = 0; i < 6; i++) chk("R5 lane order", log_b[i], mb(20'h201 + 20'(i)));
   endtask

   task automatic t_full();
      bit ok, seen;
      redirect(20'h300);
      repeat (60) @(negedge clk);
      chk("R2 no fetch when full", bus_req, 0);
      out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
      seen = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (bus_req) seen = 1'b1;
      end
      chk("R3 one free byte starts nothing", seen, 0);
      out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
      seen = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (bus_req && bus_addr == 20'h306) seen = 1'b1;
      end
      chk("R3 two free bytes start a fetch", seen, 1);
      repeat (10) @(negedge clk);
      eu_data_busy = 1'b1;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (out_valid) out_ready = 1'b1;
         else begin out_ready = 1'b0; break; end
      end
      out_ready = 1'b0;
      @(negedge clk);
      chk("R2 depth six", log_n - 2, 6);
      for (int i = 0; i < 8; i++) chk("R2 stored bytes", log_b[i], mb(20'h300 + 20'(i)));
      eu_data_busy = 1'b0;
      ok = 1'b1;
   endtask

   task automatic t_inflight();
      bit ok;
      redirect(20'h400);
      wait_fetch(20'h400, ok);
      chk("R8 first fetch seen", ok, 1);
      redir_valid = 1'b1; redir_addr = 20'h500; log_n = 0;
      @(negedge clk);
      redir_valid = 1'b0;
      chk("R8 fetch continues", bus_req, 1);
      chk("R8 address held", bus_addr, 20'h400);
      chk("R7 nothing after redirect", out_valid, 0);
      wait_fetch(20'h500, ok);
      chk("R7 refetch at new target", ok, 1);
      out_ready = 1'b1;
      wait_log(4);
      @(negedge clk); out_ready = 1'b0;
      for (int i = 0; i < 4; i++) chk("R8 stale data dropped", log_b[i], mb(20'h500 + 20'(i)));
   endtask

   task automatic t_eu_busy();
      bit ok, seen;
      redirect(20'h600);
      wait_fetch(20'h600, ok);
      chk("R9 fetch seen", ok, 1);
      @(negedge clk); eu_data_busy = 1'b1;
      @(negedge clk); chk("R9 running fetch completes", bus_req, 1);
      @(negedge clk); chk("R9 running fetch completes", bus_req, 1);
      seen = 1'b0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (bus_req) seen = 1'b1;
      end
      chk("R9 no fetch while busy", seen, 0);
      eu_data_busy = 1'b0;
      @(negedge clk);
      chk("R9 resumes", bus_req, 1);
      chk("R9 resumes at next address", bus_addr, 20'h602);
      out_ready = 1'b1;
      wait_log(4);
      @(negedge clk); out_ready = 1'b0;
      for (int i = 0; i < 4; i++) chk("R9 bytes", log_b[i], mb(20'h600 + 20'(i)));
   endtask

   task automatic t_overlap();
      redirect(20'h800);
      for (int i = 0; i < 400 && log_n < 40; i++) begin
         @(negedge clk);
         out_ready = ~out_ready;
      end
      @(negedge clk); out_ready = 1'b0;
      chk("R10 bytes received", log_n >= 40, 1);
      for (int i = 0; i < 40; i++) chk("R10 push with pop", log_b[i], mb(20'h800 + 20'(i)));
   endtask

   task automatic t_mode8();
      bit wide, seen;
      int n;
      logic [7:0] got [8];
      @(negedge clk); redir1 = 1'b1; redir_addr1 = 20'h701;
      @(negedge clk); redir1 = 1'b0;
      wide = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (bus_req1 && bus_word1) wide = 1'b1;
      end
      chk("R5 8-bit fetch is one byte", wide, 0);
      chk("R2 8-bit full stops fetching", bus_req1, 0);
      got[0] = out_data1;
      ready1 = 1'b1; @(negedge clk); ready1 = 1'b0;
      seen = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (bus_req1 && bus_addr1 == 20'h705) seen = 1'b1;
      end
      chk("R3 8-bit one free byte starts fetch", seen, 1);
      repeat (10) @(negedge clk);
      eu1 = 1'b1;
      n = 1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (out_valid1 && n < 8) begin got[n] = out_data1; n++; ready1 = 1'b1; end
         else begin ready1 = 1'b0; break; end
      end
      ready1 = 1'b0;
      chk("R2 8-bit depth four", n - 1, 4);
      for (int i = 0; i < 5; i++) chk("R5 8-bit bytes", got[i], mb(20'h701 + 20'(i)));
      eu1 = 1'b0;
   endtask

   initial begin
      t_reset();
      t_stream();
      t_odd();
      t_full();
      t_inflight();
      t_eu_busy();
      t_overlap();
      t_mode8();
      finish_run();
   end
endmodule